// File: doc/BRIEF.md
# Cascaded FIFO Slices with Token-Passed Ownership

This block builds one deep first-in/first-out buffer from several identical shallow slices that share a write strobe, a read strobe, an input data bus and an output data bus. Each slice owns its own small storage array and its own read and write pointers. It stores or delivers a word only while it holds the matching ownership token. A slice that writes its last physical location passes the write token to the next slice in a ring, and it does the same with the read token after a read from its last location. Each pass is a one-clock pulse on a two-lane hand-off bus: one lane carries write passes and the other carries read passes, so the two tokens travel independently. A first-load pin, active low, marks the slice that holds both tokens when reset ends.

The wrapper chains `NSLICE` slices in a ring. It joins their data outputs by an OR, which works because a slice without the read token drives zero. It forms the composite active-low empty and full flags by OR-ing the per-slice flags, so a composite flag asserts only when every slice asserts it. The per-slice flags are also brought out. Retransmit and a half-full indication are not part of this arrangement.

Top module: `fifo_depth_chain`

## Requirements
- R1: While reset is low, every slice clears its pointers, drives its empty flag low and its full flag high, and the composite empty is low and the composite full is high. After release only slice 0, whose first-load pin is low, holds both tokens.
- R2: A write strobe stores `wdata` only in the slice that holds the write token. Storage is at that slice's write pointer, and every other slice's occupancy stays unchanged.
- R3: A write to location DEPTH-1 of a slice raises that slice's write-pass lane for exactly that cycle. At the same clock edge the next slice in the ring (slice NSLICE-1 passes to slice 0) takes the write token and the sender gives it up.
- R4: A read from location DEPTH-1 of a slice raises its read-pass lane for that cycle and moves the read token to the next slice in the ring in the same way.
- R5: `rdata` shows the oldest stored word while the buffer is not empty, and zero when it is empty. Slices without the read token contribute zero.
- R6: Composite `empty_n` is low exactly when every slice's `slice_empty_n` is low, and composite `full_n` is low exactly when every slice's `slice_full_n` is low.
- R7: A write strobe while `full_n` is low has no effect, and a read strobe while `empty_n` is low has no effect.
- R8: Simultaneous write and read strobes are both performed, in the same slice or in different slices, as long as the buffer is neither empty (read blocked) nor full (write blocked) before the edge.
- R9: `slice_empty_n[i]` is low when slice i holds no word, and `slice_full_n[i]` is low when it holds DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Shared write strobe |
| rd_stb | input | 1 | Shared read strobe (pop) |
| wdata | input | DATA_W | Shared write data |
| rdata | output | DATA_W | Oldest stored word, zero when empty |
| empty_n | output | 1 | Composite empty flag, active low |
| full_n | output | 1 | Composite full flag, active low |
| slice_empty_n | output | NSLICE | Per-slice empty flags, active low |
| slice_full_n | output | NSLICE | Per-slice full flags, active low |

## Verification
The bench builds the ring with three slices of depth 4 and 8-bit data. With this size, a dozen writes cross every write hand-off, including the wrap from the last slice back to the first. Full and empty are each reached within a few cycles, and the bench drives both strobes into them, which tests the blocking rules. Long mixed runs put the write token and the read token in different slices during simultaneous strobes, and a behavioural queue with per-slice occupancy is compared against the outputs on every clock.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  // Hand-off bus between neighbouring slices: one lane per token.
  typedef struct packed {
    logic rd;
    logic wr;
  } xfer_t;
endpackage

// File: rtl/slice_token_ptr.sv
// One ownership token plus the ring pointer it guards (used once for write, once for read).
module slice_token_ptr #(
  parameter int DEPTH = 4,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_n,
  input  logic             stb,
  input  logic             allow,
  input  logic             pass_in,
  output logic [PTR_W-1:0] ptr,
  output logic             tok,
  output logic             fire,
  output logic             pass_out
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_nx;
  logic             tok_nx;

  assign fire     = stb & tok & allow;
  assign pass_out = fire & (ptr == LAST);

  always_comb begin
    ptr_nx = ptr;
    tok_nx = tok;
    if (fire) begin
      ptr_nx = (ptr == LAST) ? '0 : ptr + PTR_W'(1);
    end
    if (pass_out) begin
      tok_nx = 1'b0;
    end
    if (pass_in) begin
      tok_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      tok <= ~first_n;
    end else begin
      ptr <= ptr_nx;
      tok <= tok_nx;
    end
  end
endmodule

// File: rtl/chain_slice_store.sv
// Storage array of one slice: per-entry write enable, combinational read.
module chain_slice_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic hit;
    assign hit = we && (waddr == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (hit) begin
        mem[g] <= wdata;
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/chain_slice.sv
// One cascadable slice: two tokens, occupancy count, storage.
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  input  xfer_t             xin,
  output xfer_t             xout,
  output logic [DATA_W-1:0] rdata,
  output logic              empty_n,
  output logic              full_n,
  output logic              wtok,
  output logic              rtok
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [PTR_W-1:0]  wptr, rptr;
  logic              wfire, rfire;
  logic [CNT_W-1:0]  count, count_nx;
  logic [DATA_W-1:0] head;

  assign empty_n = (count != '0);
  assign full_n  = (count != CNT_FULL);

  slice_token_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .first_n(first_n),
    .stb(wr_stb), .allow(full_n), .pass_in(xin.wr),
    .ptr(wptr), .tok(wtok), .fire(wfire), .pass_out(xout.wr)
  );

  slice_token_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .first_n(first_n),
    .stb(rd_stb), .allow(empty_n), .pass_in(xin.rd),
    .ptr(rptr), .tok(rtok), .fire(rfire), .pass_out(xout.rd)
  );

  always_comb begin
    count_nx = count;
    if (wfire && !rfire) begin
      count_nx = count + CNT_W'(1);
    end else if (rfire && !wfire) begin
      count_nx = count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      count <= count_nx;
    end
  end

  chain_slice_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we(wfire), .waddr(wptr), .wdata(wdata),
    .raddr(rptr), .rdata(head)
  );

  assign rdata = (rtok && empty_n) ? head : '0;

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  // R7
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !rfire) |=> !full_n);

  // R7
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !wfire) |=> !empty_n);

  // R2
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wtok && !rtok) |=> $stable(count));
endmodule

// File: rtl/fifo_depth_chain.sv
// Ring of NSLICE slices behaving as one deep FIFO.
module fifo_depth_chain
  import fifo_chain_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int NSLICE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              empty_n,
  output logic              full_n,
  output logic [NSLICE-1:0] slice_empty_n,
  output logic [NSLICE-1:0] slice_full_n
);
  xfer_t             xo [NSLICE];
  logic [DATA_W-1:0] s_rdata [NSLICE];
  logic [NSLICE-1:0] wtok_v, rtok_v, rd_live;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int PREV = (i + NSLICE - 1) % NSLICE;
    localparam int NEXT = (i + 1) % NSLICE;
    localparam logic FIRST_N = (i == 0) ? 1'b0 : 1'b1;

    chain_slice #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_n), .first_n(FIRST_N),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .wdata(wdata),
      .xin(xo[PREV]), .xout(xo[i]), .rdata(s_rdata[i]),
      .empty_n(slice_empty_n[i]), .full_n(slice_full_n[i]),
      .wtok(wtok_v[i]), .rtok(rtok_v[i])
    );

    assign rd_live[i] = (s_rdata[i] != '0);

    if (NSLICE > 1) begin : g_pass_chk
      // R3
      wtok_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xo[i].wr |=> (wtok_v[NEXT] && !wtok_v[i]));
      // R4
      rtok_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xo[i].rd |=> (rtok_v[NEXT] && !rtok_v[i]));
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLICE; i++) begin
      rdata = rdata | s_rdata[i];
    end
  end

  assign empty_n = |slice_empty_n;
  assign full_n  = |slice_full_n;

  // R2
  wtok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wtok_v) == 1);

  // R4
  rtok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rtok_v) == 1);

  // R5
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_live));
endmodule

// File: tb/fifo_depth_chain_test.sv
module fifo_depth_chain_test;
  localparam int DW = 8;
  localparam int DP = 4;
  localparam int NS = 3;
  localparam int CAP = DP * NS;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_stb, rd_stb;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          empty_n, full_n;
  logic [NS-1:0] slice_empty_n, slice_full_n;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] q [$];
  int rpos = 0;

  always #2.5 clk = ~clk;

  fifo_depth_chain #(.DATA_W(DW), .DEPTH(DP), .NSLICE(NS)) uut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .wdata(wdata), .rdata(rdata), .empty_n(empty_n), .full_n(full_n),
    .slice_empty_n(slice_empty_n), .slice_full_n(slice_full_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    int occ [NS];
    logic [NS-1:0] e_exp, f_exp;
    for (int s = 0; s < NS; s++) occ[s] = 0;
    for (int k = 0; k < q.size(); k++) occ[((rpos + k) % CAP) / DP]++;
    for (int s = 0; s < NS; s++) begin
      e_exp[s] = (occ[s] != 0);
      f_exp[s] = (occ[s] != DP);
    end
    chk({tag, " R5 rdata"}, int'(rdata), (q.size() > 0) ? int'(q[0]) : 0);
    chk({tag, " R6 empty_n"}, int'(empty_n), int'(q.size() != 0));
    chk({tag, " R6 full_n"}, int'(full_n), int'(q.size() != CAP));
    chk({tag, " R9 slice_empty_n"}, int'(slice_empty_n), int'(e_exp));
    chk({tag, " R9 slice_full_n"}, int'(slice_full_n), int'(f_exp));
  endtask

  // Check the present state, drive one cycle of stimulus, advance the model.
  task automatic step(input string tag, input logic w, input logic r, input logic [DW-1:0] d);
    bit wacc, racc;
    check_all(tag);
    wr_stb = w;
    rd_stb = r;
    wdata  = d;
    wacc = w && (q.size() < CAP);
    racc = r && (q.size() > 0);
    if (racc) begin
      void'(q.pop_front());
      rpos = (rpos + 1) % CAP;
    end
    if (wacc) q.push_back(d);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    wr_stb = 1'b0;
    rd_stb = 1'b0;
    wdata  = '0;
    repeat (3) @(negedge clk);
    // R1: reset state of flags
    chk("R1 empty_n in reset", int'(empty_n), 0);
    chk("R1 full_n in reset", int'(full_n), 1);
    chk("R1 slice_empty_n in reset", int'(slice_empty_n), 0);
    chk("R1 slice_full_n in reset", int'(slice_full_n), (1 << NS) - 1);
    chk("R1 rdata in reset", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R7: fill across every slice, then push while full
    for (int i = 0; i < CAP + 2; i++) step("R2 R3 R7 fill", 1'b1, 1'b0, DW'(i * 29 + 3));
    // R4 R7: drain across every slice, then pop while empty
    for (int i = 0; i < CAP + 2; i++) step("R4 R7 drain", 1'b0, 1'b1, '0);
    // R7: both strobes while empty: only the write lands
    step("R7 both on empty", 1'b1, 1'b1, 8'hA5);
    // R8: stream with both strobes so tokens sit in different slices
    step("R8 prefill", 1'b1, 1'b0, 8'h11);
    step("R8 prefill", 1'b1, 1'b0, 8'h22);
    for (int i = 0; i < 40; i++) step("R8 stream", 1'b1, 1'b1, DW'(i * 13 + 7));
    // R7 R8: fill to full, then both strobes: only the read lands
    for (int i = 0; i < CAP; i++) step("R7 refill", 1'b1, 1'b0, DW'(i + 100));
    step("R7 both on full", 1'b1, 1'b1, 8'h5A);
    // R1 R6 R9: mixed traffic, several patterns
    for (int i = 0; i < 1500; i++)
      step("R1 R6 R9 mixed", ((i * 7) % 5) < 3, ((i * 3 + i / 40) % 4) < 2, DW'(i * 37 + 1));
    for (int i = 0; i < 600; i++)
      step("R6 R9 read-heavy", (i % 3) == 0, (i % 4) != 0, DW'(i * 11 + 9));
    for (int i = 0; i < 20; i++) step("R5 final drain", 1'b0, 1'b1, '0);
    check_all("R5 R6 end");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule